// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a periodic interval timer whose counter and period are 64 bits wide, accessed through a register port of 32-bit words. Software configures a clock divider, chooses between continuous and one-shot operation, stages a 64-bit period as two word-sized halves, and issues a start command. The counter then advances once per divided tick. When it reaches the period it wraps to zero and raises a sticky elapsed flag, which can drive an interrupt line. Software reads the running count as two halves without tearing.

The register port is a simple single-cycle interface. A write is taken on the clock edge where `wr_en` is high. Read data is combinational from `addr`, and the side effects of a read take place on the edge that ends the read cycle. A control state machine with two states, `ST_STOPPED` and `ST_COUNTING`, sequences the counter. It moves `ST_STOPPED -> ST_COUNTING` on a start command and `ST_COUNTING -> ST_STOPPED` on a wrap in one-shot mode. A soft reset forces `ST_STOPPED` from either state. A start while in `ST_COUNTING` stays in `ST_COUNTING` and restarts the count.

The register offsets are CTRL 0x00, MODE 0x04, PERIOD_LO 0x08, PERIOD_HI 0x0C, IRQ_EN 0x10, STATUS 0x18, COUNT_LO 0x20 and COUNT_HI 0x24. Unmapped offsets read as zero.

Top module: `pit64_timer`

## Requirements
- R1: After `rst_n` is released, every register (MODE, PERIOD_LO, PERIOD_HI, IRQ_EN, STATUS, COUNT_LO, COUNT_HI, CTRL) reads 0, `irq` is low, and the counter does not run.
- R2: Writing CTRL with bit 0 set (start) does three things on that edge: it clears the count to 0, it adopts the staged period, and it begins counting. The count then rises by one every N+1 clocks, where N is MODE bits [11:8].
- R3: Writes to PERIOD_LO and PERIOD_HI only stage a value, which reads back. The wrap point changes only on the next start command.
- R4: On a tick where the count equals the active period, the count becomes 0 and STATUS bit 0 is set.
- R5: With MODE bit 0 = 1 (continuous) the counter keeps running after a wrap. With MODE bit 0 = 0 (one-shot) it stops at 0 after the wrap and stays there.
- R6: Reading STATUS returns the flag in bit 0 and clears it. If a wrap falls on the same edge as the clear, the flag stays set.
- R7: `irq` equals STATUS bit 0 AND IRQ_EN bit 0.
- R8: Reading COUNT_LO copies the upper half of that same count into a shadow register. COUNT_HI reads return the shadow, not the live upper half.
- R9: Writing CTRL with bit 8 set (soft reset) does the following:
  - it clears count, mode, both period halves, active period, IRQ_EN, STATUS and the shadow;
  - it stops the timer;
  - it overrides a start bit in the same write.
  CTRL always reads 0.
- R10: With both period halves all ones, the counter runs freely across the boundary between its lower and upper halves without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 6 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq | output | 1 | Elapsed-flag interrupt, gated by the enable |

## Verification
The collision of interest is a STATUS read whose clear lands on the same edge as a period wrap that sets the flag. The bench starts a 5-tick continuous period and times a STATUS read so that its clearing edge is exactly the second wrap edge. It then reads STATUS twice more. The flag must still read 1 immediately after the collision, because set wins. It must read 0 after the following clean read. A second coincidence, a COUNT_LO read just before the count carries into the upper half, is exercised on a 16-bit-word instance.

// File: rtl/pit64_pkg.sv
`timescale 1ns/1ps
package pit64_pkg;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 6'h00;
    localparam logic [REG_AW-1:0] OFS_MODE   = 6'h04;
    localparam logic [REG_AW-1:0] OFS_PER_LO = 6'h08;
    localparam logic [REG_AW-1:0] OFS_PER_HI = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_IRQ_EN = 6'h10;
    localparam logic [REG_AW-1:0] OFS_STATUS = 6'h18;
    localparam logic [REG_AW-1:0] OFS_CNT_LO = 6'h20;
    localparam logic [REG_AW-1:0] OFS_CNT_HI = 6'h24;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_SRST_BIT = 8;
    localparam int MODE_CONT_BIT = 0;
    localparam int MODE_PSC_LSB  = 8;

    typedef enum logic {
        ST_STOPPED,
        ST_COUNTING
    } run_state_e;
endpackage

// File: rtl/pit64_prescaler.sv
`timescale 1ns/1ps
// Divides the clock by divider+1 while enabled; restart re-phases it.
module pit64_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [PSC_W-1:0] divider,
    output logic             tick
);
    logic [PSC_W-1:0] phase_q;

    // >= keeps the divider safe if it is lowered while counting
    assign tick = enable && (phase_q >= divider);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !enable || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PSC_W'(1);
        end
    end
endmodule

// File: rtl/pit64_counter.sv
`timescale 1ns/1ps
// Main count register with its committed period and match/wrap logic.
module pit64_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             load,
    input  logic [CNT_W-1:0] staged_period,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] active_period,
    output logic             wrap
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] period_q;

    assign wrap          = tick && (count_q == period_q);
    assign count         = count_q;
    assign active_period = period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            period_q <= '0;
        end else if (clear_all) begin
            count_q  <= '0;
            period_q <= '0;
        end else if (load) begin
            count_q  <= '0;
            period_q <= staged_period;
        end else if (tick) begin
            count_q  <= wrap ? '0 : count_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pit64_ctrl.sv
`timescale 1ns/1ps
// Run/stop sequencer.
module pit64_ctrl
    import pit64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_cmd,
    input  logic srst_cmd,
    input  logic wrap,
    input  logic continuous,
    output logic running,
    output logic load,
    output logic clear_all
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (go_cmd) state_d = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (!go_cmd && wrap && !continuous) state_d = ST_STOPPED;
            end
        endcase
        if (srst_cmd) state_d = ST_STOPPED;
    end

    always_comb begin
        running   = (state_q == ST_COUNTING);
        load      = go_cmd && !srst_cmd;
        clear_all = srst_cmd;
    end
endmodule

// File: rtl/pit64_regs.sv
`timescale 1ns/1ps
// Register file: decode, configuration, elapsed flag, count shadow, read mux.
module pit64_regs
    import pit64_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 4,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic              go_cmd,
    output logic              srst_cmd,
    output logic              continuous,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  staged_period,
    output logic              elapsed_flag,
    output logic              irq
);
    logic              cont_q;
    logic [PSC_W-1:0]  psc_q;
    logic [DATA_W-1:0] per_lo_q;
    logic [DATA_W-1:0] per_hi_q;
    logic              ien_q;
    logic              flag_q;
    logic [DATA_W-1:0] shadow_q;
    logic              ctrl_wr;
    logic              rd_status;
    logic              rd_cnt_lo;

    assign ctrl_wr   = wr_en && (addr == OFS_CTRL);
    assign go_cmd    = ctrl_wr && wdata[CTRL_GO_BIT];
    assign srst_cmd  = ctrl_wr && wdata[CTRL_SRST_BIT];
    assign rd_status = rd_en && (addr == OFS_STATUS);
    assign rd_cnt_lo = rd_en && (addr == OFS_CNT_LO);

    assign continuous    = cont_q;
    assign psc           = psc_q;
    assign staged_period = {per_hi_q, per_lo_q};
    assign elapsed_flag  = flag_q;
    assign irq           = flag_q && ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q   <= 1'b0;
            psc_q    <= '0;
            per_lo_q <= '0;
            per_hi_q <= '0;
            ien_q    <= 1'b0;
            flag_q   <= 1'b0;
            shadow_q <= '0;
        end else if (srst_cmd) begin
            cont_q   <= 1'b0;
            psc_q    <= '0;
            per_lo_q <= '0;
            per_hi_q <= '0;
            ien_q    <= 1'b0;
            flag_q   <= 1'b0;
            shadow_q <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    OFS_MODE: begin
                        cont_q <= wdata[MODE_CONT_BIT];
                        psc_q  <= wdata[MODE_PSC_LSB +: PSC_W];
                    end
                    OFS_PER_LO: per_lo_q <= wdata;
                    OFS_PER_HI: per_hi_q <= wdata;
                    OFS_IRQ_EN: ien_q    <= wdata[0];
                    default: ;
                endcase
            end
            // a wrap on the clearing edge keeps the flag set
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (rd_status) begin
                flag_q <= 1'b0;
            end
            if (rd_cnt_lo) begin
                shadow_q <= count[CNT_W-1:DATA_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE: begin
                rdata[MODE_CONT_BIT]          = cont_q;
                rdata[MODE_PSC_LSB +: PSC_W] = psc_q;
            end
            OFS_PER_LO: rdata    = per_lo_q;
            OFS_PER_HI: rdata    = per_hi_q;
            OFS_IRQ_EN: rdata[0] = ien_q;
            OFS_STATUS: rdata[0] = flag_q;
            OFS_CNT_LO: rdata    = count[DATA_W-1:0];
            OFS_CNT_HI: rdata    = shadow_q;
            default:    rdata    = '0;
        endcase
    end
endmodule

// File: rtl/pit64_timer.sv
`timescale 1ns/1ps
module pit64_timer
    import pit64_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic             go_cmd;
    logic             srst_cmd;
    logic             continuous;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] staged_period;
    logic [CNT_W-1:0] active_period;
    logic [CNT_W-1:0] count_q;
    logic             elapsed_flag;
    logic             running;
    logic             load;
    logic             clear_all;
    logic             tick;
    logic             wrap;

    pit64_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .count        (count_q),
        .wrap         (wrap),
        .go_cmd       (go_cmd),
        .srst_cmd     (srst_cmd),
        .continuous   (continuous),
        .psc          (psc),
        .staged_period(staged_period),
        .elapsed_flag (elapsed_flag),
        .irq          (irq)
    );

    pit64_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_cmd    (go_cmd),
        .srst_cmd  (srst_cmd),
        .wrap      (wrap),
        .continuous(continuous),
        .running   (running),
        .load      (load),
        .clear_all (clear_all)
    );

    pit64_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load || clear_all),
        .enable (running),
        .divider(psc),
        .tick   (tick)
    );

    pit64_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_all    (clear_all),
        .load         (load),
        .staged_period(staged_period),
        .tick         (tick),
        .count        (count_q),
        .active_period(active_period),
        .wrap         (wrap)
    );
endmodule

// File: rtl/pit64_checker.sv
`timescale 1ns/1ps
module pit64_checker
    import pit64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [REG_AW-1:0] addr,
    input logic              go_bit,
    input logic              srst_bit,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic              tick,
    input logic              running,
    input logic              flag
);
    logic ctrl_wr;
    logic go;
    logic srst;
    logic at_match;

    assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
    assign go       = ctrl_wr && go_bit;
    assign srst     = ctrl_wr && srst_bit;
    assign at_match = tick && (count == period);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !srst) |=> (count == '0));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0));

    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_match && !srst) |=> flag);

    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !go) |=> $stable(count));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_STATUS && !at_match) |=> !flag);

    assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (count == '0 && !running && !flag));
endmodule

bind pit64_timer pit64_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .go_bit  (wdata[CTRL_GO_BIT]),
    .srst_bit(wdata[CTRL_SRST_BIT]),
    .count   (count_q),
    .period  (active_period),
    .tick    (tick),
    .running (running),
    .flag    (elapsed_flag)
);

// File: tb/tb_pit64_timer.sv
`timescale 1ns/1ps
module tb_pit64_timer;
    localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_PLO = 6'h08, A_PHI = 6'h0C;
    localparam logic [5:0] A_IEN = 6'h10, A_STAT = 6'h18, A_CLO = 6'h20, A_CHI = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [15:0] rdata_n;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit narrow_sel = 1'b0;
    bit done = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] mon_e;
    logic [31:0] mon_act;
    string       mon_t;

    always #2 clk = ~clk;

    pit64_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    pit64_timer #(.DATA_W(16)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata[15:0]), .rdata(rdata_n), .irq(irq_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares every read as it happens
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underrun", rdata, 32'h0);
            end else begin
                mon_e   = exp_q.pop_front();
                mon_t   = tag_q.pop_front();
                mon_act = mon_e[32] ? {16'h0, rdata_n} : rdata;
                check(mon_act == mon_e[31:0], mon_t, mon_act, mon_e[31:0]);
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        exp_q.push_back({narrow_sel, e});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        check(irq == e, tag, {31'h0, irq}, {31'h0, e});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(A_CTRL, 0, "R1 ctrl");
        bus_read(A_MODE, 0, "R1 mode");
        bus_read(A_PLO, 0, "R1 period lo");
        bus_read(A_PHI, 0, "R1 period hi");
        bus_read(A_IEN, 0, "R1 irq enable");
        bus_read(A_STAT, 0, "R1 status");
        bus_read(A_CLO, 0, "R1 count lo");
        bus_read(A_CHI, 0, "R1 count hi");
        check_irq(1'b0, "R1 irq");

        // R2 divide by 1
        bus_write(A_MODE, 32'h1);
        bus_write(A_PLO, 1000);
        bus_read(A_MODE, 32'h1, "R2 mode readback");
        bus_write(A_CTRL, 32'h1);
        repeat (9) @(posedge clk);
        bus_read(A_CLO, 10, "R2 count div1");

        // R2 divide by 4
        bus_write(A_MODE, 32'h301);
        bus_write(A_CTRL, 32'h1);
        repeat (10) @(posedge clk);
        bus_read(A_CLO, 2, "R2 count div4");

        // R4 R5 continuous wrap, R7 gated on
        bus_write(A_CTRL, 32'h100);
        bus_write(A_MODE, 32'h1);
        bus_write(A_PLO, 4);
        bus_write(A_IEN, 1);
        bus_write(A_CTRL, 32'h1);
        repeat (6) @(posedge clk);
        bus_read(A_CLO, 2, "R4 R5 continuous after wrap");
        check_irq(1'b1, "R7 irq with enable");

        // R5 one-shot, R6 clear, R7 gating
        bus_write(A_CTRL, 32'h100);
        bus_write(A_MODE, 32'h0);
        bus_write(A_PLO, 4);
        bus_write(A_CTRL, 32'h1);
        repeat (2) @(posedge clk);
        bus_read(A_CLO, 3, "R5 one-shot counting");
        repeat (20) @(posedge clk);
        bus_read(A_CLO, 0, "R5 one-shot stopped");
        check_irq(1'b0, "R7 irq masked");
        bus_write(A_IEN, 1);
        check_irq(1'b1, "R7 irq unmasked");
        bus_read(A_STAT, 1, "R4 flag set");
        bus_read(A_STAT, 0, "R6 flag cleared");
        check_irq(1'b0, "R7 irq after clear");
        bus_read(A_CLO, 0, "R5 one-shot still stopped");

        // R3 staged period
        bus_write(A_CTRL, 32'h100);
        bus_write(A_MODE, 32'h1);
        bus_write(A_PLO, 4);
        bus_write(A_CTRL, 32'h1);
        bus_write(A_PLO, 100);
        repeat (18) @(posedge clk);
        bus_read(A_CLO, 1, "R3 old period still active");
        bus_read(A_PLO, 100, "R3 staged readback");
        bus_write(A_CTRL, 32'h1);
        repeat (29) @(posedge clk);
        bus_read(A_CLO, 30, "R3 new period after start");

        // R6 collision: clear and wrap on the same edge
        bus_write(A_CTRL, 32'h100);
        bus_write(A_MODE, 32'h1);
        bus_write(A_PLO, 4);
        bus_write(A_CTRL, 32'h1);
        repeat (8) @(posedge clk);
        bus_read(A_STAT, 1, "R6 read at wrap edge");
        bus_read(A_STAT, 1, "R6 set wins over clear");
        bus_read(A_STAT, 0, "R6 later clear");

        // R9 soft reset overrides start
        bus_write(A_CTRL, 32'h100);
        bus_write(A_MODE, 32'h301);
        bus_write(A_PLO, 2);
        bus_write(A_IEN, 1);
        bus_write(A_CTRL, 32'h1);
        repeat (30) @(posedge clk);
        bus_write(A_PHI, 5);
        bus_write(A_CTRL, 32'h101);
        bus_read(A_CTRL, 0, "R9 ctrl reads 0");
        bus_read(A_MODE, 0, "R9 mode cleared");
        bus_read(A_PLO, 0, "R9 period lo cleared");
        bus_read(A_PHI, 0, "R9 period hi cleared");
        bus_read(A_IEN, 0, "R9 irq enable cleared");
        bus_read(A_STAT, 0, "R9 status cleared");
        bus_read(A_CLO, 0, "R9 count cleared");
        repeat (10) @(posedge clk);
        bus_read(A_CLO, 0, "R9 stays stopped");
        check_irq(1'b0, "R9 irq low");

        // R8 R10 coherent halves across the carry (16-bit-word instance)
        bus_write(A_CTRL, 32'h100);
        narrow_sel = 1'b1;
        bus_write(A_MODE, 32'h1);
        bus_write(A_PLO, 32'hFFFF);
        bus_write(A_PHI, 32'hFFFF);
        bus_write(A_CTRL, 32'h1);
        repeat (65532) @(posedge clk);
        bus_read(A_CLO, 32'hFFFD, "R10 low half near carry");
        repeat (4) @(posedge clk);
        bus_read(A_CHI, 32'h0, "R8 shadow hides carry");
        bus_read(A_CLO, 32'h5, "R10 free run past carry");
        bus_read(A_CHI, 32'h1, "R8 shadow after carry");
        narrow_sel = 1'b0;

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule